// File: doc/BRIEF.md
# Serial Test-Pattern Generator with Error Injection

This block is the transmit half of a bit error rate tester. It sends a serial test stream, one bit for each cycle in which the clock enable is high. The stream is one of three patterns: a 32-bit word sent over and over, a 15-stage pseudorandom sequence, or two words that take turns, each sent a programmable number of times. Any bit of the stream can be inverted on purpose. This lets the receiving checker be shown to detect errors.

The host sets the mode, the two pattern words and the alternating count, then raises a load strobe. Only the rising edge of that strobe takes the new settings. Errors can be injected in two ways. A rising edge on the single-error strobe inverts one bit. A 3-bit rate code inverts one bit in every 10^n bits, for n from 1 to 7, and code zero turns this off. When a requested single error lands on the same bit as an automatic error, it is held and applied to the next bit.

Top module: `bert_patgen`

## Requirements
- R1: A rising edge of `load_i` takes `mode_i`, `word_a_i`, `word_b_i` and `alt_cnt_i`, and restarts the pattern at bit 31. The cycle that takes the load sends no bit, and `data_o` holds its value.
- R2: Keeping `load_i` high does not load again. A new load needs `load_i` to go low and then high.
- R3: A change on `mode_i` or on the word inputs, with no load edge, leaves the stream unchanged.
- R4: Mode code 2'b10 is alternating. Word A is sent `alt_cnt_i`+1 times, then word B is sent the same number of times, and the cycle repeats. A count of 0 gives one copy of each word in turn.
- R5: Mode code 2'b00 (and 2'b11) is repetitive. Word A is sent over and over, MSB (bit 31) first.
- R6: Mode code 2'b01 is pseudorandom. The output is the top stage q[14] of a 15-stage shift register with feedback q[14]^q[13], shifted in at bit 0 (x^15+x^14+1). The register starts from `word_a_i[14:0]`, or from all ones when that field is zero.
- R7: When `en_i` is low, the pattern does not advance and `data_o` does not change. Each enabled bit appears on `data_o` one cycle after the clock edge that samples it.
- R8: A rising edge of `sbe_i` inverts exactly one enabled bit. Keeping `sbe_i` high inverts no further bits.
- R9: A rate code n from 1 to 7 inverts every 10^n-th enabled bit. The count starts again whenever `rate_sel_i` changes, so the first error falls on enabled bit 10^n after the change.
- R10: Rate code 000 inserts no errors. After reset `data_o` is 0, and the stream is all zeros until the first load.
- R11: A single-error request that falls on a bit carrying an automatic error is held and inverts the next enabled bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Bit enable; advances the stream by one bit |
| load_i | input | 1 | Pattern load strobe, acts on its rising edge |
| sbe_i | input | 1 | Single-error strobe, acts on its rising edge |
| rate_sel_i | input | 3 | Automatic error rate code |
| alt_cnt_i | input | 8 | Copies of each word in alternating mode, minus one |
| mode_i | input | 2 | Pattern mode code |
| word_a_i | input | 32 | First pattern word and pseudorandom seed |
| word_b_i | input | 32 | Second pattern word |
| data_o | output | 1 | Serial output stream |

## Verification
The assertions check four things on every cycle. `data_o` holds while `en_i` is low. A load-edge cycle sends no bit. A held single error is used up on the next enabled bit. Two automatic errors never fall on adjacent bits.

Some behaviour can only be shown by the bench's scenarios, since it depends on a bit order over many cycles. This covers:
- the exact order of each pattern: MSB-first words, the repeat counts in alternating mode and the pseudorandom sequence against a separate model;
- the placement of errors in the decade rates;
- that holding a strobe high or changing the mode without a load has no effect.

// File: rtl/bert_pkg.sv
package bert_pkg;
  typedef enum logic [1:0] {
    MODE_REP  = 2'b00,
    MODE_PRBS = 2'b01,
    MODE_ALT  = 2'b10,
    MODE_RSVD = 2'b11
  } mode_e;

  // period in bits for a decade rate code; 0 means off
  function automatic logic [31:0] rate_period(input logic [2:0] code);
    logic [31:0] p;
    p = 32'd1;
    for (int i = 0; i < 7; i++) begin
      if (i < int'(code)) p = p * 32'd10;
    end
    return p;
  endfunction
endpackage

// File: rtl/bert_rise_det.sv
module bert_rise_det #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] lvl_q;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lvl_q[g] <= 1'b0;
      else         lvl_q[g] <= lvl_i[g];
    end
    assign rise_o[g] = lvl_i[g] & ~lvl_q[g];
  end
endmodule

// File: rtl/bert_pat_seq.sv
module bert_pat_seq
  import bert_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int ALT_W  = 8,
  parameter int LFSR_W = 15,
  parameter int TAP_B  = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              adv_i,
  input  logic [1:0]        mode_i,
  input  logic [WORD_W-1:0] word_a_i,
  input  logic [WORD_W-1:0] word_b_i,
  input  logic [ALT_W-1:0]  alt_cnt_i,
  output logic              pat_o
);
  localparam int IDX_W = $clog2(WORD_W);
  localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(WORD_W - 1);

  mode_e             mode_q;
  logic [WORD_W-1:0] word_a_q, word_b_q;
  logic [ALT_W-1:0]  alt_q, rep_q;
  logic [IDX_W-1:0]  idx_q;
  logic              sel_b_q;
  logic [LFSR_W-1:0] lfsr_q, seed;
  logic [WORD_W-1:0] cur_word;
  logic              fb;

  assign seed     = (word_a_i[LFSR_W-1:0] == '0) ? '1 : word_a_i[LFSR_W-1:0];
  assign fb       = lfsr_q[LFSR_W-1] ^ lfsr_q[TAP_B];
  assign cur_word = (mode_q == MODE_ALT && sel_b_q) ? word_b_q : word_a_q;

  always_comb begin
    if (mode_q == MODE_PRBS) pat_o = lfsr_q[LFSR_W-1];
    else                     pat_o = cur_word[idx_q];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= MODE_REP;
      word_a_q <= '0;
      word_b_q <= '0;
      alt_q    <= '0;
      rep_q    <= '0;
      idx_q    <= IDX_TOP;
      sel_b_q  <= 1'b0;
      lfsr_q   <= '1;
    end else if (load_i) begin
      mode_q   <= mode_e'(mode_i);
      word_a_q <= word_a_i;
      word_b_q <= word_b_i;
      alt_q    <= alt_cnt_i;
      rep_q    <= '0;
      idx_q    <= IDX_TOP;
      sel_b_q  <= 1'b0;
      lfsr_q   <= seed;
    end else if (adv_i) begin
      if (mode_q == MODE_PRBS) begin
        lfsr_q <= {lfsr_q[LFSR_W-2:0], fb};
      end else begin
        idx_q <= (idx_q == '0) ? IDX_TOP : idx_q - 1'b1;
        // word boundary: count copies, swap words after alt_q+1 copies
        if (idx_q == '0 && mode_q == MODE_ALT) begin
          if (rep_q == alt_q) begin
            rep_q   <= '0;
            sel_b_q <= ~sel_b_q;
          end else begin
            rep_q <= rep_q + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/bert_err_ins.sv
module bert_err_ins
  import bert_pkg::*;
#(
  parameter int RATE_W = 3,
  parameter int CNT_W  = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_en_i,
  input  logic              sbe_rise_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              err_o,
  output logic              auto_o,
  output logic              pend_o
);
  logic [RATE_W-1:0] rate_q;
  logic [CNT_W-1:0]  cnt_q, last;
  logic              rate_chg, req, pend_q;

  assign rate_chg = rate_i != rate_q;
  assign last     = CNT_W'(rate_period(3'(rate_i)) - 32'd1);
  assign auto_o   = bit_en_i && rate_i != '0 && !rate_chg && cnt_q == last;
  assign req      = sbe_rise_i | pend_q;
  assign err_o    = bit_en_i & (auto_o | req);
  assign pend_o   = pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rate_q <= '0;
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      rate_q <= rate_i;
      if (rate_chg || rate_i == '0) cnt_q <= '0;
      else if (bit_en_i)            cnt_q <= auto_o ? '0 : cnt_q + 1'b1;
      // a request colliding with an automatic error waits one bit
      if (bit_en_i) pend_q <= req & auto_o;
      else          pend_q <= req;
    end
  end
endmodule

// File: rtl/bert_patgen.sv
module bert_patgen #(
  parameter int WORD_W = 32,
  parameter int ALT_W  = 8,
  parameter int RATE_W = 3,
  parameter int LFSR_W = 15,
  parameter int CNT_W  = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              load_i,
  input  logic              sbe_i,
  input  logic [RATE_W-1:0] rate_sel_i,
  input  logic [ALT_W-1:0]  alt_cnt_i,
  input  logic [1:0]        mode_i,
  input  logic [WORD_W-1:0] word_a_i,
  input  logic [WORD_W-1:0] word_b_i,
  output logic              data_o
);
  logic [1:0] rise;
  logic       load_rise, sbe_rise, bit_en, pat, err, auto_err, sbe_pend, data_q;

  bert_rise_det #(.N(2)) u_rise (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i ({sbe_i, load_i}),
    .rise_o(rise)
  );
  assign load_rise = rise[0];
  assign sbe_rise  = rise[1];
  assign bit_en    = en_i & ~load_rise;

  bert_pat_seq #(
    .WORD_W(WORD_W),
    .ALT_W (ALT_W),
    .LFSR_W(LFSR_W),
    .TAP_B (LFSR_W - 2)
  ) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load_rise),
    .adv_i    (bit_en),
    .mode_i   (mode_i),
    .word_a_i (word_a_i),
    .word_b_i (word_b_i),
    .alt_cnt_i(alt_cnt_i),
    .pat_o    (pat)
  );

  bert_err_ins #(.RATE_W(RATE_W), .CNT_W(CNT_W)) u_err (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bit_en_i  (bit_en),
    .sbe_rise_i(sbe_rise),
    .rate_i    (rate_sel_i),
    .err_o     (err),
    .auto_o    (auto_err),
    .pend_o    (sbe_pend)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     data_q <= 1'b0;
    else if (bit_en) data_q <= pat ^ err;
  end
  assign data_o = data_q;
endmodule

// File: rtl/bert_patgen_chk.sv
module bert_patgen_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic load_i,
  input logic data_o,
  input logic bit_en,
  input logic auto_err,
  input logic sbe_pend
);
  assert_hold_when_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(data_o));

  assert_load_sends_no_bit_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(load_i) |=> $stable(data_o));

  assert_pending_used_next_bit_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sbe_pend && bit_en) |=> !sbe_pend);

  assert_auto_errs_spaced_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    auto_err |=> !auto_err);
endmodule

bind bert_patgen bert_patgen_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .en_i    (en_i),
  .load_i  (load_i),
  .data_o  (data_o),
  .bit_en  (bit_en),
  .auto_err(auto_err),
  .sbe_pend(sbe_pend)
);

// File: tb/bert_patgen_tb.sv
module bert_patgen_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0, rst_ni = 1'b0, en_i = 1'b0, load_i = 1'b0, sbe_i = 1'b0;
  logic [2:0]  rate_sel_i = '0;
  logic [7:0]  alt_cnt_i = '0;
  logic [1:0]  mode_i = '0;
  logic [31:0] word_a_i = '0, word_b_i = '0;
  logic        data_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic got [0:511];

  bert_patgen u_dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic step(input logic en);
    en_i = en;
    @(posedge clk_i);
    #1;
  endtask

  task automatic collect(input int from, input int n);
    for (int i = from; i < from + n; i++) begin
      step(1'b1);
      got[i] = data_o;
    end
  endtask

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_load(input logic [1:0] m, input logic [31:0] a, input logic [31:0] b,
                         input logic [7:0] c);
    mode_i = m; word_a_i = a; word_b_i = b; alt_cnt_i = c;
    load_i = 1'b1; step(1'b0);
    load_i = 1'b0; step(1'b0);
  endtask

  function automatic int word_mism(input logic [31:0] w, input int from, input int n);
    int m = 0;
    for (int i = 0; i < n; i++) if (got[from+i] !== w[31 - (i % 32)]) m++;
    return m;
  endfunction

  task automatic t_reset();
    check("R10", "reset data_o", int'(data_o), 0);
    collect(0, 40);
    check("R10", "ones before any load", word_mism(32'h0, 0, 40), 0);
  endtask

  task automatic t_repeat();
    do_load(2'b00, 32'hA5C3_0F96, 32'h0, 8'h0);
    collect(0, 96);
    check("R5", "repetitive mismatches", word_mism(32'hA5C3_0F96, 0, 96), 0);
    do_load(2'b11, 32'h8001_7FFE, 32'h0, 8'h0);
    collect(0, 64);
    check("R5", "code 11 mismatches", word_mism(32'h8001_7FFE, 0, 64), 0);
  endtask

  task automatic t_reload_edge();
    mode_i = 2'b00; word_a_i = 32'hF0F0_1234;
    load_i = 1'b1; step(1'b1);
    check("R1", "load cycle holds data_o", int'(data_o), 0);
    word_a_i = 32'h0BAD_CAFE;
    collect(0, 64);
    check("R2", "held strobe reloaded", word_mism(32'hF0F0_1234, 0, 64), 0);
    load_i = 1'b0; step(1'b0);
    load_i = 1'b1; step(1'b0);
    collect(0, 64);
    check("R1", "fresh edge not loaded", word_mism(32'h0BAD_CAFE, 0, 64), 0);
    load_i = 1'b0;
    collect(0, 5);
    do_load(2'b00, 32'h1357_9BDF, 32'h0, 8'h0);
    collect(0, 7);
    mode_i = 2'b01; word_a_i = 32'hFFFF_0000;
    collect(7, 57);
    check("R1", "restart at MSB", word_mism(32'h1357_9BDF, 0, 7), 0);
    check("R3", "mode/word change w/o load", word_mism(32'h1357_9BDF, 0, 64), 0);
  endtask

  task automatic t_enable();
    logic held;
    int m;
    do_load(2'b00, 32'h6B2D_94E1, 32'h0, 8'h0);
    collect(0, 5);
    held = data_o;
    m = 0;
    for (int i = 0; i < 6; i++) begin
      step(1'b0);
      if (data_o !== held) m++;
    end
    check("R7", "changes while en low", m, 0);
    collect(5, 59);
    check("R7", "stream after pause", word_mism(32'h6B2D_94E1, 0, 64), 0);
  endtask

  task automatic t_prbs(input logic [31:0] a);
    logic [14:0] s;
    int m = 0;
    s = (a[14:0] == '0) ? 15'h7FFF : a[14:0];
    do_load(2'b01, a, 32'h0, 8'h0);
    collect(0, 200);
    for (int i = 0; i < 200; i++) begin
      if (got[i] !== s[14]) m++;
      s = {s[13:0], s[14] ^ s[13]};
    end
    check("R6", $sformatf("prbs seed %0h mismatches", a), m, 0);
  endtask

  task automatic t_alt(input logic [7:0] c, input int words);
    int m = 0;
    do_load(2'b10, 32'hC3C3_5AA5, 32'h0F1E_2D3C, c);
    collect(0, words * 32);
    for (int w = 0; w < words; w++) begin
      logic [31:0] exp_w;
      exp_w = (((w / (int'(c) + 1)) % 2) == 0) ? 32'hC3C3_5AA5 : 32'h0F1E_2D3C;
      m += word_mism(exp_w, w * 32, 32);
    end
    check("R4", $sformatf("alternating count %0d mismatches", c), m, 0);
  endtask

  function automatic int ones_mism(input int n, input int period, input int extra);
    int m = 0;
    for (int i = 0; i < n; i++) begin
      logic e;
      e = ((period != 0) && ((i % period) == period - 1)) || (i == extra);
      if (got[i] !== e) m++;
    end
    return m;
  endfunction

  task automatic t_single();
    do_load(2'b00, 32'h0, 32'h0, 8'h0);
    rate_sel_i = 3'd0; step(1'b0);
    collect(0, 5);
    sbe_i = 1'b1;
    collect(5, 45);
    check("R8", "single error placement", ones_mism(50, 0, 5), 0);
    sbe_i = 1'b0;
    step(1'b0);
  endtask

  task automatic t_rates();
    do_load(2'b00, 32'h0, 32'h0, 8'h0);
    rate_sel_i = 3'd1; step(1'b0);
    collect(0, 100);
    check("R9", "rate 1e-1 placement", ones_mism(100, 10, -1), 0);
    rate_sel_i = 3'd2; step(1'b0);
    collect(0, 300);
    check("R9", "rate 1e-2 placement", ones_mism(300, 100, -1), 0);
    rate_sel_i = 3'd1; collect(0, 4);
    rate_sel_i = 3'd2; step(1'b0);
    collect(0, 150);
    check("R9", "counter restart on change", ones_mism(150, 100, -1), 0);
    rate_sel_i = 3'd0; step(1'b0);
    collect(0, 300);
    check("R10", "rate 000 inserts none", ones_mism(300, 0, -1), 0);
  endtask

  task automatic t_collision();
    do_load(2'b00, 32'h0, 32'h0, 8'h0);
    rate_sel_i = 3'd1; step(1'b0);
    collect(0, 9);
    sbe_i = 1'b1;
    collect(9, 21);
    check("R11", "deferred single error", ones_mism(30, 10, 10), 0);
    sbe_i = 1'b0; rate_sel_i = 3'd0; step(1'b0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    step(1'b0);
    t_reset();
    t_repeat();
    t_reload_edge();
    t_enable();
    t_prbs(32'h0000_1234);
    t_prbs(32'hABCD_0000);
    t_alt(8'd1, 8);
    t_alt(8'd0, 6);
    t_single();
    t_rates();
    t_collision();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule